// File: doc/BRIEF.md
# Command and Transmit-Word Queue Pair

This block sits between a serial host-side front end and an audio serial-bus engine. It holds two short queues side by side. One holds 8-bit commands and the other holds 16-bit transmit words. The front end writes a command, then the data word that belongs to it. The engine drains both queues at fixed bit positions inside each 16-bit serial word. The queue occupancies are exported as 2-bit fill codes, and the host reads them in its status byte to decide whether it can send more.

A command is accepted only if its top bit (the check bit) is 1. A data word is accepted only if it is the first data word after an accepted command. The engine supplies a bit strobe and a run level. While run is high, the block counts strobes within the word. On the 15th strobe it takes the next command, and on the 16th strobe it takes the next data word. The values taken are held on the current-command and current-word outputs until the next take.

Top module: `xq_queue_pair`

## Requirements
- R1: During reset and right after reset, both fill codes are 00, both current outputs are zero and both overflow flags are 0.
- R2: A command write whose bit 7 (check bit) is 0 is ignored. The command fill code and the command queue contents do not change.
- R3: A data-word write is accepted only if an accepted command has been written since the last data-word write. Any other data-word write is ignored and leaves the data fill code unchanged.
- R4: Each fill code is the binary occupancy of its queue: 00 empty, 01 one entry, 10 two entries, 11 three entries (full).
- R5: A write to a full queue in a cycle with no take from that queue is dropped. The queue keeps its contents and its fill code of 11. The overflow flag for that queue goes to 1 and stays at 1 until reset.
- R6: Entries leave each queue in the order they were written. A take places the oldest entry on the current output in the next cycle.
- R7: With run high, strobes are numbered from 1 within a 16-strobe word. The command queue is taken on strobe 15 and the data queue on strobe 16. Each fill code changes in the cycle after the strobe that takes from it. After strobe 16 the numbering restarts at 1.
- R8: A take from an empty queue leaves the fill code at 00 and leaves the current output holding its last value.
- R9: A write and a take on the same queue in the same cycle leave its fill code unchanged. If the queue is empty, the written value goes directly to the current output. If the queue is full, the write is accepted and is not an overflow.
- R10: While run is low, strobes take nothing and the strobe numbering returns to 1. The next strobe with run high is strobe 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_push_i | input | 1 | Command write strobe |
| cmd_byte_i | input | 8 | Command byte, bit 7 is the check bit |
| data_push_i | input | 1 | Data-word write strobe |
| data_word_i | input | 16 | Transmit data word |
| run_i | input | 1 | Engine running; low resets the strobe numbering |
| bit_stb_i | input | 1 | One pulse per serial bit time |
| cmd_cur_o | output | 8 | Most recently taken command |
| data_cur_o | output | 16 | Most recently taken data word |
| cmd_fill_o | output | 2 | Command queue fill code |
| data_fill_o | output | 2 | Data queue fill code |
| cmd_ovf_o | output | 1 | Sticky command overflow flag |
| data_ovf_o | output | 1 | Sticky data overflow flag |

## Verification
Directed sequences cover the following cases:
- Commands with the check bit cleared, and data words with no command before them, which separate R2 and R3 from ordinary writes.
- Fill to three entries and then a fourth write, which exposes the fill-code encoding and overflow handling.
- Runs of exactly 14, 15 and 16 strobes, which pin the take positions to strobes 15 and 16 and not one strobe either side.
- A write timed to land on the taking strobe, both with the queue empty and with one entry, which separates the bypass case from ordinary accounting.
- Strobes with run low, followed by a short count, which show whether the numbering really restarts.

A long random phase mixes writes, strobes and run drops. A behavioural queue model checks every output on every cycle.

// File: rtl/xq_pkg.sv
// Package: shared defaults and the pop-strobe bundle for the queue pair.
// Assumes a single clock domain for writers, engine and queues.
package xq_pkg;
    localparam int XQ_DEPTH     = 3;
    localparam int XQ_CMD_W     = 8;
    localparam int XQ_DATA_W    = 16;
    localparam int XQ_WORD_BITS = 16;

    // Take requests produced by the bit-slot timer.
    typedef struct packed {
        logic cmd;
        logic data;
    } xq_pops_t;
endpackage

// File: rtl/xq_fifo.sv
// Module: small synchronous queue with occupancy count, held head output,
// sticky overflow flag and empty bypass.
// Assumes DEPTH >= 2. A take frees a slot in the same cycle, so a write
// to a full queue is accepted if a take happens in that cycle.
module xq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [WIDTH-1:0]             push_data_i,
    input  logic                         pop_i,
    output logic [WIDTH-1:0]             head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         ovf_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [WIDTH-1:0] head_q;
    logic             ovf_q;

    logic is_empty, is_full, bypass, do_pop, do_push, drop;

    // Decide which of write, take, bypass and drop happen this cycle.
    always_comb begin
        is_empty = (cnt_q == '0);
        is_full  = (cnt_q == FULL_CNT);
        bypass   = pop_i && push_i && is_empty;
        do_pop   = pop_i && !is_empty;
        do_push  = push_i && !bypass && (!is_full || do_pop);
        drop     = push_i && is_full && !pop_i;
    end

    // Storage write and write pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (do_push) begin
            slot_q[wr_ptr_q] <= push_data_i;
            wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
        end
    end

    // Read pointer advance and held head value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            head_q   <= '0;
        end else if (bypass) begin
            head_q <= push_data_i;
        end else if (do_pop) begin
            head_q   <= slot_q[rd_ptr_q];
            rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
        end
    end

    // Occupancy counter and sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
            if (drop) ovf_q <= 1'b1;
        end
    end

    assign head_o  = head_q;
    assign count_o = cnt_q;
    assign ovf_o   = ovf_q;

    // R4: occupancy never exceeds the depth.
    p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
    // R5: overflow flag is sticky.
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    // R5: a dropped write leaves the queue full.
    p_drop_keeps_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && is_full && !pop_i) |=> (cnt_q == FULL_CNT) && ovf_q);
    // R8: a take from empty with no write holds the head and the count.
    p_pop_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && is_empty) |=> $stable(head_q) && (cnt_q == '0));
    // R9: write plus take keeps the count.
    p_push_pop_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && push_i) |=> $stable(cnt_q));
endmodule

// File: rtl/xq_slot_timer.sv
// Module: counts bit strobes within a serial word and raises the command
// take on strobe WORD_BITS-1 and the data take on strobe WORD_BITS.
// Assumes bit_stb_i is a one-cycle pulse. run_i low clears the count.
module xq_slot_timer
    import xq_pkg::*;
#(
    parameter int WORD_BITS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_i,
    input  logic     bit_stb_i,
    output xq_pops_t pops_o
);
    localparam int POS_W = $clog2(WORD_BITS);
    localparam logic [POS_W-1:0] CMD_SLOT  = POS_W'(WORD_BITS - 2);
    localparam logic [POS_W-1:0] DATA_SLOT = POS_W'(WORD_BITS - 1);

    logic [POS_W-1:0] pos_q;
    logic             live;

    // Take strobes are decoded from the position of the current strobe.
    always_comb begin
        live        = run_i && bit_stb_i;
        pops_o.cmd  = live && (pos_q == CMD_SLOT);
        pops_o.data = live && (pos_q == DATA_SLOT);
    end

    // Bit position within the word; wraps after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) pos_q <= '0;
        else if (bit_stb_i)   pos_q <= (pos_q == DATA_SLOT) ? '0 : pos_q + 1'b1;
    end

    // R7: the two takes never coincide.
    p_take_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pops_o.cmd, pops_o.data}));
    // R7: after a command take, the next strobe takes data.
    p_data_follows_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pops_o.cmd |=> (pos_q == DATA_SLOT) || !run_i);
    // R10: no take while stopped.
    p_idle_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !(pops_o.cmd || pops_o.data));
endmodule

// File: rtl/xq_frame_gate.sv
// Module: accepts a command only when its check bit is set, and accepts
// one data word per accepted command.
// Assumes the data word of a frame is written after its command byte.
module xq_frame_gate #(
    parameter int CMD_W     = 8,
    parameter int CHECK_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_push_i,
    input  logic [CMD_W-1:0] cmd_byte_i,
    input  logic             data_push_i,
    output logic             cmd_acc_o,
    output logic             data_acc_o
);
    logic armed_q;

    // Gate both writes.
    always_comb begin
        cmd_acc_o  = cmd_push_i && cmd_byte_i[CHECK_BIT];
        data_acc_o = data_push_i && armed_q;
    end

    // Armed after an accepted command, disarmed by any data write.
    always_ff @(posedge clk) begin
        if (!rst_n)           armed_q <= 1'b0;
        else if (cmd_acc_o)   armed_q <= 1'b1;
        else if (data_push_i) armed_q <= 1'b0;
    end

    // R3: once a data word is accepted, another one needs a new command first.
    p_one_word_per_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc_o && !cmd_acc_o) |=> !data_acc_o);
endmodule

// File: rtl/xq_queue_pair.sv
// Module: top of the command/data queue pair. It joins the frame gate,
// the bit-slot timer and two queues.
// Assumes writers and engine share clk. Overflow is avoided by host polling.
module xq_queue_pair
    import xq_pkg::*;
#(
    parameter int DEPTH     = XQ_DEPTH,
    parameter int CMD_W     = XQ_CMD_W,
    parameter int DATA_W    = XQ_DATA_W,
    parameter int WORD_BITS = XQ_WORD_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_push_i,
    input  logic [CMD_W-1:0]           cmd_byte_i,
    input  logic                       data_push_i,
    input  logic [DATA_W-1:0]          data_word_i,
    input  logic                       run_i,
    input  logic                       bit_stb_i,
    output logic [CMD_W-1:0]           cmd_cur_o,
    output logic [DATA_W-1:0]          data_cur_o,
    output logic [$clog2(DEPTH+1)-1:0] cmd_fill_o,
    output logic [$clog2(DEPTH+1)-1:0] data_fill_o,
    output logic                       cmd_ovf_o,
    output logic                       data_ovf_o
);
    localparam int CHECK_BIT = CMD_W - 1;

    logic     cmd_acc, data_acc;
    xq_pops_t pops;

    xq_frame_gate #(.CMD_W(CMD_W), .CHECK_BIT(CHECK_BIT)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_push_i (cmd_push_i),
        .cmd_byte_i (cmd_byte_i),
        .data_push_i(data_push_i),
        .cmd_acc_o  (cmd_acc),
        .data_acc_o (data_acc)
    );

    xq_slot_timer #(.WORD_BITS(WORD_BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_i),
        .bit_stb_i(bit_stb_i),
        .pops_o   (pops)
    );

    xq_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_cmd_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (cmd_acc),
        .push_data_i(cmd_byte_i),
        .pop_i      (pops.cmd),
        .head_o     (cmd_cur_o),
        .count_o    (cmd_fill_o),
        .ovf_o      (cmd_ovf_o)
    );

    xq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_data_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (data_acc),
        .push_data_i(data_word_i),
        .pop_i      (pops.data),
        .head_o     (data_cur_o),
        .count_o    (data_fill_o),
        .ovf_o      (data_ovf_o)
    );

    // R2: an unchecked command with no take leaves the command fill alone.
    p_unchecked_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_push_i && !cmd_byte_i[CHECK_BIT] && !pops.cmd) |=> $stable(cmd_fill_o));
    // R7: the data queue is never taken in the cycle right after reset release.
    p_no_early_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pops.data);
endmodule

// File: tb/tb_xq_queue_pair.sv
module tb_xq_queue_pair;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_push_i = 1'b0;
    logic [7:0]  cmd_byte_i = '0;
    logic        data_push_i = 1'b0;
    logic [15:0] data_word_i = '0;
    logic        run_i = 1'b0;
    logic        bit_stb_i = 1'b0;
    logic [7:0]  cmd_cur_o;
    logic [15:0] data_cur_o;
    logic [1:0]  cmd_fill_o, data_fill_o;
    logic        cmd_ovf_o, data_ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 0;
    bit done = 0;

    xq_queue_pair dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_push_i(cmd_push_i), .cmd_byte_i(cmd_byte_i),
        .data_push_i(data_push_i), .data_word_i(data_word_i),
        .run_i(run_i), .bit_stb_i(bit_stb_i),
        .cmd_cur_o(cmd_cur_o), .data_cur_o(data_cur_o),
        .cmd_fill_o(cmd_fill_o), .data_fill_o(data_fill_o),
        .cmd_ovf_o(cmd_ovf_o), .data_ovf_o(data_ovf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Behavioural reference model
    int  mq_c[$];
    int  mq_d[$];
    int  m_ch, m_dh, m_pos;
    bit  m_co, m_do, m_armed;
    bit  cp, dp, cpu, dpu;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq_c.delete(); mq_d.delete();
            m_ch = 0; m_dh = 0; m_pos = 0; m_co = 0; m_do = 0; m_armed = 0;
        end else begin
            cp = run_i && bit_stb_i && (m_pos == 14);
            dp = run_i && bit_stb_i && (m_pos == 15);
            if (!run_i) m_pos = 0;
            else if (bit_stb_i) m_pos = (m_pos + 1) % 16;
            cpu = cmd_push_i && cmd_byte_i[7];
            dpu = data_push_i && m_armed;
            if (cpu) m_armed = 1;
            else if (data_push_i) m_armed = 0;
            // command queue
            if (cp && cpu && mq_c.size() == 0) m_ch = int'(cmd_byte_i);
            else begin
                if (cp && mq_c.size() > 0) m_ch = mq_c.pop_front();
                if (cpu) begin
                    if (mq_c.size() < 3) mq_c.push_back(int'(cmd_byte_i));
                    else m_co = 1;
                end
            end
            // data queue
            if (dp && dpu && mq_d.size() == 0) m_dh = int'(data_word_i);
            else begin
                if (dp && mq_d.size() > 0) m_dh = mq_d.pop_front();
                if (dpu) begin
                    if (mq_d.size() < 3) mq_d.push_back(int'(data_word_i));
                    else m_do = 1;
                end
            end
            cmp_on = 1;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R6 cmd head", int'(cmd_cur_o), m_ch);
            chk("R6 data head", int'(data_cur_o), m_dh);
            chk("R4 cmd fill", int'(cmd_fill_o), mq_c.size());
            chk("R4 data fill", int'(data_fill_o), mq_d.size());
            chk("R5 cmd ovf", int'(cmd_ovf_o), int'(m_co));
            chk("R5 data ovf", int'(data_ovf_o), int'(m_do));
        end
    end

    task automatic cyc(input logic cpush, input logic [7:0] c,
                       input logic dpush, input logic [15:0] d, input logic s);
        @(negedge clk); #1;
        cmd_push_i = cpush; cmd_byte_i = c;
        data_push_i = dpush; data_word_i = d; bit_stb_i = s;
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 1'b0, 16'h0000, 1'b0);
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 8'h00, 1'b0, 16'h0000, 1'b1);
            idle();
        end
    endtask

    task automatic set_run(input logic v);
        @(negedge clk); #1; run_i = v;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle();
        // R1 reset state
        chk("R1 cmd fill", int'(cmd_fill_o), 0);
        chk("R1 data fill", int'(data_fill_o), 0);
        chk("R1 cmd cur", int'(cmd_cur_o), 0);
        chk("R1 ovf", int'({cmd_ovf_o, data_ovf_o}), 0);

        // R2 unchecked command ignored; R3 orphan data ignored
        cyc(1, 8'h35, 0, 0, 0); idle();
        chk("R2 unchecked cmd", int'(cmd_fill_o), 0);
        cyc(0, 0, 1, 16'h5A5A, 0); idle();
        chk("R3 orphan data", int'(data_fill_o), 0);

        // R4/R5 fill to three, then overflow
        cyc(1, 8'h81, 0, 0, 0); cyc(0, 0, 1, 16'h1111, 0); idle();
        chk("R4 code 01", int'(cmd_fill_o), 1);
        cyc(1, 8'h82, 0, 0, 0); cyc(0, 0, 1, 16'h2222, 0); idle();
        chk("R4 code 10", int'(data_fill_o), 2);
        cyc(1, 8'h83, 0, 0, 0); cyc(0, 0, 1, 16'h3333, 0); idle();
        chk("R4 code 11", int'(cmd_fill_o), 3);
        cyc(1, 8'h84, 0, 0, 0); cyc(0, 0, 1, 16'h4444, 0); idle();
        chk("R5 cmd ovf", int'(cmd_ovf_o), 1);
        chk("R5 data ovf", int'(data_ovf_o), 1);
        chk("R5 full kept", int'(data_fill_o), 3);

        // R7 take positions
        set_run(1);
        strobes(14);
        chk("R7 no take at 14", int'(cmd_fill_o), 3);
        strobes(1);
        chk("R7 cmd take at 15", int'(cmd_fill_o), 2);
        chk("R7 cmd head", int'(cmd_cur_o), 'h81);
        chk("R7 data waits", int'(data_fill_o), 3);
        strobes(1);
        chk("R7 data take at 16", int'(data_fill_o), 2);
        chk("R6 data head", int'(data_cur_o), 'h1111);

        // drain, then R8 take from empty
        strobes(32);
        chk("R6 last cmd", int'(cmd_cur_o), 'h83);
        chk("R6 last data", int'(data_cur_o), 'h3333);
        strobes(16);
        chk("R8 cmd fill", int'(cmd_fill_o), 0);
        chk("R8 cmd hold", int'(cmd_cur_o), 'h83);
        chk("R8 data hold", int'(data_cur_o), 'h3333);

        // R9 bypass on empty
        strobes(14);
        cyc(1, 8'h9A, 0, 0, 1); idle();
        chk("R9 bypass fill", int'(cmd_fill_o), 0);
        chk("R9 bypass cmd", int'(cmd_cur_o), 'h9A);
        cyc(0, 0, 1, 16'hBEEF, 1); idle();
        chk("R9 bypass data", int'(data_cur_o), 'hBEEF);

        // R9 write and take with one entry
        cyc(1, 8'hA1, 0, 0, 0); cyc(0, 0, 1, 16'hA1A1, 0); idle();
        strobes(14);
        cyc(1, 8'hA2, 0, 0, 1); idle();
        chk("R9 cmd fill kept", int'(cmd_fill_o), 1);
        chk("R9 cmd head", int'(cmd_cur_o), 'hA1);
        cyc(0, 0, 1, 16'hA2A2, 1); idle();
        chk("R9 data fill kept", int'(data_fill_o), 1);

        // R3 orphan data after a completed frame
        cyc(0, 0, 1, 16'h7777, 0); idle();
        chk("R3 second data ignored", int'(data_fill_o), 1);

        // R10 run low clears position
        strobes(5);
        set_run(0);
        strobes(20);
        chk("R10 no take when stopped", int'(cmd_fill_o), 1);
        set_run(1);
        strobes(10);
        chk("R10 position restarted", int'(cmd_fill_o), 1);
        strobes(5);
        chk("R10 take at new 15", int'(cmd_fill_o), 0);
        chk("R10 head", int'(cmd_cur_o), 'hA2);

        // random mix, checked against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); #1;
            cmd_push_i  = ($urandom_range(0, 5) == 0);
            cmd_byte_i  = 8'($urandom);
            data_push_i = ($urandom_range(0, 4) == 0);
            data_word_i = 16'($urandom);
            bit_stb_i   = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 99) == 0) run_i = ~run_i;
        end
        idle();
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule